// File: doc/BRIEF.md
# Byte-Parity Registered Bus Transceiver

This block joins two 16-bit buses, side A and side B, that each carry one parity bit per data byte. Each direction of transfer has its own storage stage. The stage is either transparent, or it shows the word captured at the last rising edge of that direction's clock. Each direction has its own output-enable qualifier, which tells the pad logic when the outgoing data may drive the bus.

On the A-to-B path, a mode input selects one of two behaviours:
- **Generate:** the parity bits are computed from the data, and they travel through the storage stage with the data.
- **Check:** the parity received with the data is passed on and checked.

The B-to-A path only checks.

A single odd/even select sets the parity sense for both directions. Each direction reports one error flag, covering both of its bytes. The flag is modelled as an open-drain pull-down, which allows wire-OR: an active-low level plus a drive-enable. The flag is only driven while that direction's output is enabled.

Top module: `byte_parity_xcvr`

## Requirements
- R1: While a direction's latch enable is high, its outputs follow its inputs combinationally. On the A-to-B path in check mode, both data and parity follow.
- R2: While a direction's latch enable is low, its outputs show the word captured at the most recent rising edge of that direction's clock. With no edge, that word is held.
- R3: The controls of one direction (clock, latch enable, output enable) have no effect on the other direction's outputs.
- R4: `b_drv_o` equals `ab_oe_i` and `a_drv_o` equals `ba_oe_i`. The data outputs carry the stage value whatever the enable is.
- R5: In generate mode (`gen_mode_i`=1), parity bit k is computed for byte k, which is data bits [8k+7:8k]. The bit is chosen so that the byte plus the bit has odd weight when `odd_sel_i`=1, and even weight when `odd_sel_i`=0.
- R6: Generated parity passes through the A-to-B storage stage, so a held output word keeps the parity of the data it was captured with.
- R7: In A-to-B check mode, the error condition is true when either byte at the stage output breaks the selected parity sense. It follows the stored word, not the live input.
- R8: In generate mode, the A-to-B error flag is never driven, whatever `a_par_i` carries.
- R9: The B-to-A path checks parity at its stage output whatever the value of `gen_mode_i`.
- R10: An error flag is driven (`*_err_drv_o`=1, `*_err_n_o`=0) only when its direction's output enable is high and an error is present. Otherwise the flag reads 1 with drive 0.
- R11: `odd_sel_i` sets the parity sense of both directions at once.
- R12: An active-low asynchronous reset clears both stored words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of both stages |
| ab_clk_i | input | 1 | A-to-B capture clock |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_oe_i | input | 1 | A-to-B output enable |
| gen_mode_i | input | 1 | A-to-B parity role: 1 = generate, 0 = check |
| ba_clk_i | input | 1 | B-to-A capture clock |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_oe_i | input | 1 | B-to-A output enable |
| odd_sel_i | input | 1 | Parity sense for both paths: 1 = odd, 0 = even |
| a_data_i | input | 16 | Data arriving on side A |
| a_par_i | input | 2 | Byte parity arriving on side A |
| b_data_i | input | 16 | Data arriving on side B |
| b_par_i | input | 2 | Byte parity arriving on side B |
| b_data_o | output | 16 | Data toward side B |
| b_par_o | output | 2 | Byte parity toward side B |
| b_drv_o | output | 1 | Drive qualifier for side B outputs |
| ab_err_n_o | output | 1 | A-to-B error flag level, active low |
| ab_err_drv_o | output | 1 | A-to-B error flag pull-down enable |
| a_data_o | output | 16 | Data toward side A |
| a_par_o | output | 2 | Byte parity toward side A |
| a_drv_o | output | 1 | Drive qualifier for side A outputs |
| ba_err_n_o | output | 1 | B-to-A error flag level, active low |
| ba_err_drv_o | output | 1 | B-to-A error flag pull-down enable |

## Verification
The hardest case to reach is a flag raised by a stored word while the live input is clean, with nothing changing at the ports. This is a stale error held in the stage. To reach it, the stimulus captures a word with a corrupted parity bit while latch enable is low. It then gates that direction's clock off and presents correct data. The flag must stay asserted until the clock runs again.

The same gating lets the bench show held generated parity. It also shows that one direction's controls leave the other direction alone: one clock is stopped while the other keeps capturing.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

   // Parity sense shared by both transfer directions
   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_sense_e;

   // What the storage stage presents at its output
   typedef enum logic {
      FLOW_STORED = 1'b0,
      FLOW_PASS   = 1'b1
   } flow_e;

   // Parity role of a direction in the current cycle
   typedef enum logic {
      ROLE_CHECK = 1'b0,
      ROLE_GEN   = 1'b1
   } par_role_e;

endpackage

// File: rtl/bpx_stage.sv
module bpx_stage #(
   parameter int W = 18
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         le_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   import bpx_pkg::*;

   logic [W-1:0] held_q;
   flow_e        flow;

   // The register samples on every edge; latch enable only picks the view.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= '0;
      end else begin
         held_q <= d_i;
      end
   end

   assign flow = le_i ? FLOW_PASS : FLOW_STORED;

   always_comb begin
      unique case (flow)
         FLOW_PASS:   q_o = d_i;
         FLOW_STORED: q_o = held_q;
         default:     q_o = held_q;
      endcase
   end

endmodule

// File: rtl/bpx_par_sel.sv
module bpx_par_sel #(
   parameter int NB      = 2,
   parameter int BW      = 8,
   parameter bit CAN_GEN = 1'b1,
   localparam int DW     = NB * BW
) (
   input  logic          gen_i,
   input  logic          odd_i,
   input  logic [DW-1:0] data_i,
   input  logic [NB-1:0] par_i,
   output logic [NB-1:0] par_o
);
   import bpx_pkg::*;

   generate
      if (CAN_GEN) begin : g_gen
         par_sense_e    sense;
         par_role_e     role;
         logic [NB-1:0] made_par;

         assign sense = par_sense_e'(odd_i);
         assign role  = par_role_e'(gen_i);

         for (genvar k = 0; k < NB; k++) begin : g_byte
            assign made_par[k] = (^data_i[k*BW +: BW]) ^ (sense == PAR_ODD);
         end

         assign par_o = (role == ROLE_GEN) ? made_par : par_i;
      end else begin : g_pass
         logic unused_ctl;
         logic unused_data;
         assign unused_ctl  = gen_i ^ odd_i;
         assign unused_data = ^data_i;
         assign par_o       = par_i;
      end
   endgenerate

endmodule

// File: rtl/bpx_par_check.sv
module bpx_par_check #(
   parameter int NB  = 2,
   parameter int BW  = 8,
   localparam int DW = NB * BW
) (
   input  logic          odd_i,
   input  logic [DW-1:0] data_i,
   input  logic [NB-1:0] par_i,
   output logic          err_o
);
   import bpx_pkg::*;

   par_sense_e    sense;
   logic [NB-1:0] byte_bad;

   assign sense = par_sense_e'(odd_i);

   generate
      for (genvar k = 0; k < NB; k++) begin : g_byte
         // Weight of byte plus its parity bit must match the sense.
         assign byte_bad[k] = (^{data_i[k*BW +: BW], par_i[k]}) != (sense == PAR_ODD);
      end
   endgenerate

   assign err_o = |byte_bad;

endmodule

// File: rtl/bpx_dir.sv
module bpx_dir #(
   parameter int NB      = 2,
   parameter int BW      = 8,
   parameter bit CAN_GEN = 1'b1,
   localparam int DW     = NB * BW,
   localparam int SW     = DW + NB
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          le_i,
   input  logic          oe_i,
   input  logic          gen_i,
   input  logic          odd_i,
   input  logic [DW-1:0] data_i,
   input  logic [NB-1:0] par_i,
   output logic [DW-1:0] data_o,
   output logic [NB-1:0] par_o,
   output logic          drv_o,
   output logic          err_n_o,
   output logic          err_drv_o
);
   import bpx_pkg::*;

   logic [NB-1:0] sel_par;
   logic [SW-1:0] stage_d;
   logic [SW-1:0] stage_q;
   logic          chk_err;
   logic          chk_en;
   logic          err_live;

   bpx_par_sel #(
      .NB      (NB),
      .BW      (BW),
      .CAN_GEN (CAN_GEN)
   ) u_sel (
      .gen_i  (gen_i),
      .odd_i  (odd_i),
      .data_i (data_i),
      .par_i  (par_i),
      .par_o  (sel_par)
   );

   assign stage_d = {sel_par, data_i};

   bpx_stage #(
      .W (SW)
   ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .le_i   (le_i),
      .d_i    (stage_d),
      .q_o    (stage_q)
   );

   assign data_o = stage_q[DW-1:0];
   assign par_o  = stage_q[SW-1:DW];

   bpx_par_check #(
      .NB (NB),
      .BW (BW)
   ) u_chk (
      .odd_i  (odd_i),
      .data_i (data_o),
      .par_i  (par_o),
      .err_o  (chk_err)
   );

   generate
      if (CAN_GEN) begin : g_role
         assign chk_en = (par_role_e'(gen_i) == ROLE_CHECK);
      end else begin : g_fixed
         assign chk_en = 1'b1;
      end
   endgenerate

   assign err_live  = chk_err & chk_en;
   assign drv_o     = oe_i;
   assign err_drv_o = oe_i & err_live;
   assign err_n_o   = ~(oe_i & err_live);

endmodule

// File: rtl/byte_parity_xcvr.sv
module byte_parity_xcvr #(
   parameter int BYTES  = 2,
   parameter int BYTE_W = 8
) (
   input  logic                      rst_ni,
   input  logic                      ab_clk_i,
   input  logic                      ab_le_i,
   input  logic                      ab_oe_i,
   input  logic                      gen_mode_i,
   input  logic                      ba_clk_i,
   input  logic                      ba_le_i,
   input  logic                      ba_oe_i,
   input  logic                      odd_sel_i,
   input  logic [BYTES*BYTE_W-1:0]   a_data_i,
   input  logic [BYTES-1:0]          a_par_i,
   input  logic [BYTES*BYTE_W-1:0]   b_data_i,
   input  logic [BYTES-1:0]          b_par_i,
   output logic [BYTES*BYTE_W-1:0]   b_data_o,
   output logic [BYTES-1:0]          b_par_o,
   output logic                      b_drv_o,
   output logic                      ab_err_n_o,
   output logic                      ab_err_drv_o,
   output logic [BYTES*BYTE_W-1:0]   a_data_o,
   output logic [BYTES-1:0]          a_par_o,
   output logic                      a_drv_o,
   output logic                      ba_err_n_o,
   output logic                      ba_err_drv_o
);

   generate
      if (BYTES < 1) begin : g_bad_bytes
         $error("byte_parity_xcvr: BYTES must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_width
         $error("byte_parity_xcvr: BYTE_W must be at least 1");
      end
   endgenerate

   // A to B: parity may be generated or checked
   bpx_dir #(
      .NB      (BYTES),
      .BW      (BYTE_W),
      .CAN_GEN (1'b1)
   ) u_ab (
      .clk_i     (ab_clk_i),
      .rst_ni    (rst_ni),
      .le_i      (ab_le_i),
      .oe_i      (ab_oe_i),
      .gen_i     (gen_mode_i),
      .odd_i     (odd_sel_i),
      .data_i    (a_data_i),
      .par_i     (a_par_i),
      .data_o    (b_data_o),
      .par_o     (b_par_o),
      .drv_o     (b_drv_o),
      .err_n_o   (ab_err_n_o),
      .err_drv_o (ab_err_drv_o)
   );

   // B to A: check only
   bpx_dir #(
      .NB      (BYTES),
      .BW      (BYTE_W),
      .CAN_GEN (1'b0)
   ) u_ba (
      .clk_i     (ba_clk_i),
      .rst_ni    (rst_ni),
      .le_i      (ba_le_i),
      .oe_i      (ba_oe_i),
      .gen_i     (1'b0),
      .odd_i     (odd_sel_i),
      .data_i    (b_data_i),
      .par_i     (b_par_i),
      .data_o    (a_data_o),
      .par_o     (a_par_o),
      .drv_o     (a_drv_o),
      .err_n_o   (ba_err_n_o),
      .err_drv_o (ba_err_drv_o)
   );

endmodule

// File: rtl/bpx_chk.sv
module bpx_chk #(
   parameter int BYTES  = 2,
   parameter int BYTE_W = 8,
   localparam int DW    = BYTES * BYTE_W
) (
   input logic             rst_ni,
   input logic             ab_clk_i,
   input logic             ab_le_i,
   input logic             ab_oe_i,
   input logic             gen_mode_i,
   input logic             ba_clk_i,
   input logic             ba_le_i,
   input logic             ba_oe_i,
   input logic             odd_sel_i,
   input logic [DW-1:0]    a_data_i,
   input logic [BYTES-1:0] a_par_i,
   input logic [DW-1:0]    b_data_i,
   input logic [BYTES-1:0] b_par_i,
   input logic [DW-1:0]    b_data_o,
   input logic [BYTES-1:0] b_par_o,
   input logic             ab_err_n_o,
   input logic             ab_err_drv_o,
   input logic [DW-1:0]    a_data_o,
   input logic [BYTES-1:0] a_par_o,
   input logic             ba_err_n_o,
   input logic             ba_err_drv_o
);

   function automatic logic word_bad(input logic [DW-1:0] d,
                                     input logic [BYTES-1:0] p,
                                     input logic odd);
      logic bad;
      int   ones;
      bad = 1'b0;
      for (int k = 0; k < BYTES; k++) begin
         ones = $countones(d[k*BYTE_W +: BYTE_W]) + int'(p[k]);
         if ((ones % 2 == 1) != odd) bad = 1'b1;
      end
      return bad;
   endfunction

   logic ab_seen;
   logic ba_seen;

   always_ff @(posedge ab_clk_i or negedge rst_ni) begin
      if (!rst_ni) ab_seen <= 1'b0;
      else         ab_seen <= 1'b1;
   end

   always_ff @(posedge ba_clk_i or negedge rst_ni) begin
      if (!rst_ni) ba_seen <= 1'b0;
      else         ba_seen <= 1'b1;
   end

   // R1
   ab_pass_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      ab_le_i |-> b_data_o == a_data_i);

   // R2
   ab_hold_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      (ab_seen && !ab_le_i) |-> b_data_o == $past(a_data_i));

   // R2
   ab_hold_par_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      (ab_seen && !ab_le_i && !$past(gen_mode_i)) |-> b_par_o == $past(a_par_i));

   // R2
   ba_hold_chk: assert property (@(posedge ba_clk_i) disable iff (!rst_ni)
      (ba_seen && !ba_le_i) |-> {a_par_o, a_data_o} == $past({b_par_i, b_data_i}));

   // R5
   ab_gen_good_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      (gen_mode_i && ab_le_i) |-> !word_bad(b_data_o, b_par_o, odd_sel_i));

   // R7
   ab_check_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      (ab_oe_i && !gen_mode_i) |-> ab_err_drv_o == word_bad(b_data_o, b_par_o, odd_sel_i));

   // R8
   ab_gen_quiet_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      gen_mode_i |-> (ab_err_n_o && !ab_err_drv_o));

   // R9
   ba_check_chk: assert property (@(posedge ba_clk_i) disable iff (!rst_ni)
      ba_oe_i |-> ba_err_drv_o == word_bad(a_data_o, a_par_o, odd_sel_i));

   // R10
   ab_flag_off_chk: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
      !ab_oe_i |-> (ab_err_n_o && !ab_err_drv_o));

   // R10
   ba_flag_off_chk: assert property (@(posedge ba_clk_i) disable iff (!rst_ni)
      !ba_oe_i |-> (ba_err_n_o && !ba_err_drv_o));

endmodule

bind byte_parity_xcvr bpx_chk #(
   .BYTES  (BYTES),
   .BYTE_W (BYTE_W)
) u_bpx_chk (
   .rst_ni       (rst_ni),
   .ab_clk_i     (ab_clk_i),
   .ab_le_i      (ab_le_i),
   .ab_oe_i      (ab_oe_i),
   .gen_mode_i   (gen_mode_i),
   .ba_clk_i     (ba_clk_i),
   .ba_le_i      (ba_le_i),
   .ba_oe_i      (ba_oe_i),
   .odd_sel_i    (odd_sel_i),
   .a_data_i     (a_data_i),
   .a_par_i      (a_par_i),
   .b_data_i     (b_data_i),
   .b_par_i      (b_par_i),
   .b_data_o     (b_data_o),
   .b_par_o      (b_par_o),
   .ab_err_n_o   (ab_err_n_o),
   .ab_err_drv_o (ab_err_drv_o),
   .a_data_o     (a_data_o),
   .a_par_o      (a_par_o),
   .ba_err_n_o   (ba_err_n_o),
   .ba_err_drv_o (ba_err_drv_o)
);

// File: tb/byte_parity_xcvr_bench.sv
`timescale 1ns/1ps
module byte_parity_xcvr_bench;
   localparam int NB = 2;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic ab_run = 1'b1;
   logic ba_run = 1'b1;
   logic ab_clk;
   logic ba_clk;
   assign ab_clk = clk & ab_run;
   assign ba_clk = clk & ba_run;

   logic          rst_n = 1'b0;
   logic          ab_le = 1'b0, ab_oe = 1'b0, gen = 1'b0;
   logic          ba_le = 1'b0, ba_oe = 1'b0, odd = 1'b0;
   logic [DW-1:0] a_d = '0, b_d = '0;
   logic [NB-1:0] a_p = '0, b_p = '0;
   logic [DW-1:0] b_data_o, a_data_o;
   logic [NB-1:0] b_par_o, a_par_o;
   logic          b_drv_o, a_drv_o, ab_err_n_o, ab_err_drv_o, ba_err_n_o, ba_err_drv_o;

   byte_parity_xcvr #(.BYTES(NB), .BYTE_W(BW)) u_byte_parity_xcvr (
      .rst_ni(rst_n), .ab_clk_i(ab_clk), .ab_le_i(ab_le), .ab_oe_i(ab_oe),
      .gen_mode_i(gen), .ba_clk_i(ba_clk), .ba_le_i(ba_le), .ba_oe_i(ba_oe),
      .odd_sel_i(odd), .a_data_i(a_d), .a_par_i(a_p), .b_data_i(b_d), .b_par_i(b_p),
      .b_data_o(b_data_o), .b_par_o(b_par_o), .b_drv_o(b_drv_o),
      .ab_err_n_o(ab_err_n_o), .ab_err_drv_o(ab_err_drv_o),
      .a_data_o(a_data_o), .a_par_o(a_par_o), .a_drv_o(a_drv_o),
      .ba_err_n_o(ba_err_n_o), .ba_err_drv_o(ba_err_drv_o));

   int    n_chk  = 0;
   int    n_fail = 0;
   string req    = "R12";

   // Behavioural reference: one stored word per direction
   logic [DW+NB-1:0] m_ab = '0;
   logic [DW+NB-1:0] m_ba = '0;

   function automatic logic [NB-1:0] make_par(input logic [DW-1:0] d, input logic o);
      logic [NB-1:0] r;
      for (int k = 0; k < NB; k++) begin
         r[k] = ($countones(d[k*BW +: BW]) % 2 == 1) ? ~o : o;
      end
      return r;
   endfunction

   function automatic logic is_bad(input logic [DW-1:0] d, input logic [NB-1:0] p,
                                   input logic o);
      logic b;
      b = 1'b0;
      for (int k = 0; k < NB; k++) begin
         if ((($countones(d[k*BW +: BW]) + int'(p[k])) % 2 == 1) != o) b = 1'b1;
      end
      return b;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ab <= '0;
         m_ba <= '0;
      end else begin
         if (ab_run) m_ab <= {(gen ? make_par(a_d, odd) : a_p), a_d};
         if (ba_run) m_ba <= {b_p, b_d};
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [DW+NB-1:0] ab_w, ba_w;
      logic             ab_e, ba_e;
      ab_w = ab_le ? {(gen ? make_par(a_d, odd) : a_p), a_d} : m_ab;
      ba_w = ba_le ? {b_p, b_d} : m_ba;
      ab_e = ab_oe && !gen && is_bad(ab_w[DW-1:0], ab_w[DW+NB-1:DW], odd);
      ba_e = ba_oe && is_bad(ba_w[DW-1:0], ba_w[DW+NB-1:DW], odd);
      chk("b_data", 32'(b_data_o), 32'(ab_w[DW-1:0]));
      chk("b_par", 32'(b_par_o), 32'(ab_w[DW+NB-1:DW]));
      chk("b_drv", 32'(b_drv_o), 32'(ab_oe));
      chk("ab_err_n", 32'(ab_err_n_o), 32'(!ab_e));
      chk("ab_err_drv", 32'(ab_err_drv_o), 32'(ab_e));
      chk("a_data", 32'(a_data_o), 32'(ba_w[DW-1:0]));
      chk("a_par", 32'(a_par_o), 32'(ba_w[DW+NB-1:DW]));
      chk("a_drv", 32'(a_drv_o), 32'(ba_oe));
      chk("ba_err_n", 32'(ba_err_n_o), 32'(!ba_e));
      chk("ba_err_drv", 32'(ba_err_drv_o), 32'(ba_e));
   endtask

   // Inputs are set while clk is low; compare, clock once, compare again
   task automatic step();
      #0.5 compare();
      @(posedge clk);
      @(negedge clk);
      #0.5 compare();
   endtask

   logic done = 1'b0;

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R12: reset clears both stored words
      odd = 1'b1;
      @(negedge clk);
      #0.5 compare();
      @(negedge clk);
      #0.5 compare();
      rst_n = 1'b1;
      ab_oe = 1'b1;
      ba_oe = 1'b1;
      #0.5 compare();

      // R1: transparent paths, check mode, several words
      req = "R1";
      ab_le = 1'b1;
      ba_le = 1'b1;
      odd   = 1'b0;
      for (int i = 0; i < 8; i++) begin
         a_d = DW'($urandom);
         b_d = DW'($urandom);
         a_p = make_par(a_d, odd);
         b_p = make_par(b_d, odd);
         step();
      end

      // R2: clocked capture, then held with the clocks gated
      req = "R2";
      ab_le = 1'b0;
      ba_le = 1'b0;
      for (int i = 0; i < 6; i++) begin
         a_d = DW'($urandom);
         b_d = DW'($urandom);
         a_p = NB'($urandom);
         b_p = NB'($urandom);
         step();
      end
      ab_run = 1'b0;
      ba_run = 1'b0;
      for (int i = 0; i < 3; i++) begin
         a_d = ~a_d;
         b_d = b_d + 16'h1357;
         step();
      end

      // R3: the B-to-A side keeps running while A-to-B controls toggle
      req = "R3";
      ba_run = 1'b1;
      for (int i = 0; i < 6; i++) begin
         ab_le = i[0];
         ab_oe = i[1];
         b_d = DW'($urandom);
         b_p = make_par(b_d, odd);
         step();
      end
      ab_run = 1'b1;
      ba_run = 1'b0;
      for (int i = 0; i < 4; i++) begin
         ba_le = 1'b0;
         ba_oe = i[0];
         a_d = DW'($urandom);
         step();
      end
      ba_run = 1'b1;

      // R4: output qualifiers follow the enables, data unaffected
      req = "R4";
      ab_le = 1'b0;
      for (int i = 0; i < 4; i++) begin
         ab_oe = i[0];
         ba_oe = i[1];
         a_d = DW'($urandom);
         step();
      end
      ab_oe = 1'b1;
      ba_oe = 1'b1;

      // R5: generated parity, both senses, transparent
      req = "R5";
      gen = 1'b1;
      ab_le = 1'b1;
      for (int i = 0; i < 8; i++) begin
         odd = i[0];
         a_d = (i == 2) ? 16'h0000 : (i == 3) ? 16'hFFFF : DW'($urandom);
         a_p = NB'($urandom);
         step();
      end

      // R6: generated parity stays with the held data
      req = "R6";
      ab_le = 1'b0;
      odd = 1'b1;
      a_d = 16'h0301;
      step();
      ab_run = 1'b0;
      a_d = 16'h0700;
      step();
      step();
      ab_run = 1'b1;

      // R8: generate mode ignores bad incoming parity
      req = "R8";
      a_d = 16'h00FF;
      a_p = 2'b11;
      step();

      // R7: check mode, one bad byte, other bad byte, both, then stale error
      req = "R7";
      gen = 1'b0;
      odd = 1'b0;
      a_d = 16'h1234;
      a_p = make_par(a_d, odd) ^ 2'b01;
      step();
      a_p = make_par(a_d, odd) ^ 2'b10;
      step();
      a_p = make_par(a_d, odd) ^ 2'b11;
      step();
      ab_run = 1'b0;
      a_p = make_par(a_d, odd);
      step();
      ab_run = 1'b1;
      step();

      // R9: B-to-A checks regardless of the mode select
      req = "R9";
      gen = 1'b1;
      ba_le = 1'b0;
      b_d = 16'hA5C3;
      b_p = make_par(b_d, odd) ^ 2'b10;
      step();
      b_p = make_par(b_d, odd);
      step();

      // R10: flags suppressed while the enable is low
      req = "R10";
      gen = 1'b0;
      b_p = make_par(b_d, odd) ^ 2'b01;
      a_p = make_par(a_d, odd) ^ 2'b01;
      ab_oe = 1'b0;
      ba_oe = 1'b0;
      step();
      ab_oe = 1'b1;
      ba_oe = 1'b1;
      step();

      // R11: one sense select flips both directions
      req = "R11";
      a_p = make_par(a_d, 1'b0);
      b_p = make_par(b_d, 1'b0);
      odd = 1'b0;
      step();
      odd = 1'b1;
      step();

      // R12: asynchronous reset mid-run
      req = "R12";
      rst_n = 1'b0;
      #0.5 compare();
      @(negedge clk);
      rst_n = 1'b1;
      step();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule